// File: doc/BRIEF.md
# Receive Byte Queue with Fill Trigger and Idle Timeout

This block is the receive side buffer of a serial controller. It holds up to sixteen bytes that arrive from the bit-level deserializer and hands them to the processor one at a time, oldest first, whenever the receive data register is read. Arriving bytes are taken in only while the receive path is enabled. A byte that arrives when the queue is full is thrown away.

A ready flag tells the processor that the queue needs service. The flag rises as soon as a push brings the fill level to the programmed trigger level. The flag also rises when bytes have sat below that level with no further arrival for fifteen character times, so a short message still gets serviced. The character time is an input given in clock cycles. The flag is gated by an interrupt enable to form the interrupt request. A control write selects one of four trigger levels and can flush the queue.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset the fill level is 0, the ready flag and the interrupt are low, and the read data output is 0.
- R2: A byte on the push port is stored only in a cycle where `push_valid` and `rx_enable` are both high. With `rx_enable` low, the fill level does not change.
- R3: When the fill level is 16, a pushed byte is discarded, and the 16 stored bytes stay intact and in order.
- R4: `pop_data` shows the oldest stored byte. A `pop` strobe removes that byte, and the storage wraps around past the last entry. With the queue empty, `pop_data` is 0 and a `pop` changes nothing.
- R5: The trigger level is selected by `cfg_trig` on a `cfg_wr` cycle: code 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14 (the reset code is 0). A push that brings the fill level to the trigger level or above sets the ready flag on the same clock edge.
- R6: A pop that leaves the fill level below the trigger level clears the ready flag.
- R7: A push that leaves the fill level below the trigger level restarts an idle timer of 15 × `etu_cycles` clock cycles. If no other push arrives, the ready flag is set exactly 15 × `etu_cycles` edges after that push, provided the queue is not empty at that point.
- R8: A push that reaches the trigger level cancels a running idle timer.
- R9: A `cfg_wr` cycle with `cfg_flush` high empties the queue, clears the ready flag and cancels the idle timer. It takes priority over a push or pop in the same cycle.
- R10: A push and a pop accepted in the same cycle leave the fill level unchanged. The popped byte is the oldest one.
- R11: `irq` is high exactly when the ready flag is high and `irq_enable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive path enable; gates the push port |
| irq_enable | input | 1 | Receive interrupt enable |
| etu_cycles | input | 16 | Character time unit in clock cycles |
| push_valid | input | 1 | A received byte is offered this cycle |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Receive data register read strobe |
| pop_data | output | 8 | Oldest stored byte, 0 when empty |
| cfg_wr | input | 1 | Control write strobe |
| cfg_trig | input | 2 | Trigger level code |
| cfg_flush | input | 1 | Flush request, taken on a control write |
| fill_level | output | 5 | Number of stored bytes |
| ready | output | 1 | Ready flag |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench sweeps all four trigger codes. For each code it fills the queue one byte at a time and checks the ready flag after every push, which shows whether the flag rises at the exact level or one byte early or late. A full run of sixteen bytes plus one extra byte, followed by sixteen reads with a known pattern, tells correct ordering and pointer wraparound apart from dropped or overwritten entries. Timed idle periods check the exact expiry cycle, a restart caused by a later push, cancellation by a flush, and the empty-queue case. The timer limit is checked one cycle before and at expiry. Separate runs cover a disabled receive path, reads from an empty queue, and a push and a pop in the same cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   typedef enum logic [1:0] {
      TRG_SINGLE  = 2'd0,
      TRG_QUARTER = 2'd1,
      TRG_HALF    = 2'd2,
      TRG_NEAR    = 2'd3
   } trig_code_e;

   // Maps a trigger code onto one of four configured byte levels.
   function automatic int trig_bytes(trig_code_e c, int l0, int l1, int l2, int l3);
      case (c)
         TRG_SINGLE:  return l0;
         TRG_QUARTER: return l1;
         TRG_HALF:    return l2;
         default:     return l3;
      endcase
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[i] <= '0;
         else if (wr_en && (wr_idx == AW'(i)))
            slot[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < DEPTH; k++)
         if (rd_idx == AW'(k)) rd_data = slot[k];
   end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_ok,
   input  logic          pop_ok,
   input  logic          flush,
   output logic [AW-1:0] head,
   output logic [AW-1:0] tail,
   output logic [CW-1:0] count
);
   localparam bit POW2 = (DEPTH == (1 << AW));
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] head_inc, tail_inc;

   if (POW2) begin : g_wrap_natural
      assign head_inc = head + AW'(1);
      assign tail_inc = tail + AW'(1);
   end else begin : g_wrap_compare
      assign head_inc = (head == LAST) ? '0 : head + AW'(1);
      assign tail_inc = (tail == LAST) ? '0 : tail + AW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else if (flush) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push_ok) head <= head_inc;
         if (pop_ok)  tail <= tail_inc;
         if (push_ok && !pop_ok)      count <= count + CW'(1);
         else if (pop_ok && !push_ok) count <= count - CW'(1);
      end
   end

   AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R3
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> count == '0); // R9
   AST_BOTH_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                      (push_ok && pop_ok && !flush) |=> $stable(count)); // R10
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
   parameter int ETU_W = 16,
   parameter int CHARS = 15,
   localparam int TMR_W = ETU_W + $clog2(CHARS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             cancel,
   input  logic [ETU_W-1:0] etu,
   output logic             expire
);
   localparam logic [TMR_W-1:0] K = TMR_W'(CHARS);

   logic [TMR_W-1:0] tmr;
   logic [TMR_W-1:0] load;

   assign load   = K * TMR_W'(etu);
   assign expire = (tmr == TMR_W'(1)) && !restart && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            tmr <= '0;
      else if (cancel)       tmr <= '0;
      else if (restart)      tmr <= load;
      else if (tmr != '0)    tmr <= tmr - TMR_W'(1);
   end

   AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cancel |=> !expire); // R8
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 16,
   parameter int ETU_W   = 16,
   parameter int TO_CHARS = 15,
   parameter int TRIG_L0 = 1,
   parameter int TRIG_L1 = 4,
   parameter int TRIG_L2 = 8,
   parameter int TRIG_L3 = 14,
   localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic              irq_enable,
   input  logic [ETU_W-1:0]  etu_cycles,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_trig,
   input  logic              cfg_flush,
   output logic [CW-1:0]     fill_level,
   output logic              ready,
   output logic              irq
);
   import rxq_pkg::*;

   if (TRIG_L0 < 1 || TRIG_L1 < 1 || TRIG_L2 < 1 || TRIG_L3 < 1) begin : g_bad_low
      $error("trigger levels must be at least one byte");
   end
   if (TRIG_L0 > DEPTH || TRIG_L1 > DEPTH || TRIG_L2 > DEPTH || TRIG_L3 > DEPTH) begin : g_bad_high
      $error("trigger levels must not exceed the depth");
   end
   if (TO_CHARS < 1 || DEPTH < 2) begin : g_bad_cfg
      $error("idle timeout and depth must be positive");
   end

   trig_code_e        trig_q;
   logic [CW-1:0]     trig_lvl;
   logic [AW-1:0]     head, tail;
   logic [CW-1:0]     count, next_cnt;
   logic [DATA_W-1:0] slot_out;
   logic              flush, push_ok, pop_ok, reach, expire, flag_q;

   assign flush    = cfg_wr && cfg_flush;
   assign push_ok  = push_valid && rx_enable && (count != CW'(DEPTH)) && !flush;
   assign pop_ok   = pop && (count != '0) && !flush;
   assign next_cnt = count + CW'(push_ok) - CW'(pop_ok);
   assign trig_lvl = CW'(trig_bytes(trig_q, TRIG_L0, TRIG_L1, TRIG_L2, TRIG_L3));
   assign reach    = push_ok && (next_cnt >= trig_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      trig_q <= TRG_SINGLE;
      else if (cfg_wr) trig_q <= trig_code_e'(cfg_trig);
   end

   rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok), .flush(flush),
      .head(head), .tail(tail), .count(count)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_idx(head), .wr_data(push_data),
      .rd_idx(tail), .rd_data(slot_out)
   );

   rxq_timeout #(.ETU_W(ETU_W), .CHARS(TO_CHARS)) u_tmo (
      .clk(clk), .rst_n(rst_n),
      .restart(push_ok && !reach), .cancel(flush || reach),
      .etu(etu_cycles), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q <= 1'b0;
      else if (flush)                      flag_q <= 1'b0;
      else if (reach)                      flag_q <= 1'b1;
      else if (expire && next_cnt != '0)   flag_q <= 1'b1;
      else if (pop_ok && next_cnt < trig_lvl) flag_q <= 1'b0;
   end

   assign pop_data   = (count == '0) ? '0 : slot_out;
   assign fill_level = count;
   assign ready      = flag_q;
   assign irq        = flag_q && irq_enable;

   AST_DISABLED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
                           (!rx_enable && !pop && !cfg_wr) |=> $stable(fill_level)); // R2
   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                      (fill_level == '0) |-> (pop_data == '0)); // R4
   AST_TRIG_SET: assert property (@(posedge clk) disable iff (!rst_n)
                    (push_ok && !pop_ok && (count + CW'(1) >= trig_lvl)) |=> ready); // R5
   AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !ready); // R9
endmodule

// File: tb/tb_serial_rx_queue.sv
module tb_serial_rx_queue;
   logic clk = 0, rst_n = 0;
   logic rx_enable = 0, irq_enable = 0, push_valid = 0, pop = 0;
   logic cfg_wr = 0, cfg_flush = 0;
   logic [1:0] cfg_trig = 0;
   logic [15:0] etu_cycles = 16'd2;
   logic [7:0] push_data = 0;
   logic [7:0] pop_data;
   logic [4:0] fill_level;
   logic ready, irq;
   int n_chk = 0, n_bad = 0;
   localparam int WIN = 30; // 15 * etu_cycles

   always #2 clk = ~clk;

   serial_rx_queue dut (.*);

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      push_valid = 1; push_data = b;
      @(negedge clk);
      push_valid = 0;
   endtask

   task automatic popone();
      pop = 1;
      @(negedge clk);
      pop = 0;
   endtask

   task automatic cfg(input logic [1:0] code, input logic fl);
      cfg_wr = 1; cfg_trig = code; cfg_flush = fl;
      @(negedge clk);
      cfg_wr = 0; cfg_flush = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int lv [4] = '{1, 4, 8, 14};
      idle(2);
      check("R1 level", fill_level, 0);
      check("R1 ready", ready, 0);
      check("R1 irq", irq, 0);
      check("R1 data", pop_data, 0);
      rst_n = 1;
      @(negedge clk);
      rx_enable = 1;

      // R5 / R6 sweep over all trigger codes
      for (int c = 0; c < 4; c++) begin
         cfg(2'(c), 1'b1);
         for (int k = 1; k <= lv[c]; k++) begin
            push(8'(k));
            check($sformatf("R5 code%0d n%0d", c, k), ready, (k >= lv[c]) ? 1 : 0);
         end
         popone();
         check($sformatf("R6 code%0d", c), ready, 0);
      end

      // R3 / R4 full, discard, order with wrap (pointers start mid-array)
      cfg(2'd3, 1'b1);
      push(8'h11); popone(); push(8'h12); popone(); push(8'h13); popone();
      for (int i = 0; i < 16; i++) push(8'h30 + 8'(i));
      check("R3 full", fill_level, 16);
      push(8'hEE);
      check("R3 discard", fill_level, 16);
      for (int i = 0; i < 16; i++) begin
         check("R4 order", pop_data, 8'h30 + i);
         popone();
         check("R6 ready", ready, (15 - i >= 14) ? 1 : 0);
      end
      check("R4 empty", fill_level, 0);
      check("R4 empty data", pop_data, 0);
      popone();
      check("R4 empty pop", fill_level, 0);

      // R2 disabled path
      rx_enable = 0;
      push(8'h55);
      check("R2 gated", fill_level, 0);
      rx_enable = 1;
      push(8'h56);
      check("R2 enabled", fill_level, 1);

      // R10 simultaneous push and pop
      cfg(2'd2, 1'b1);
      push(8'h61); push(8'h62); push(8'h63);
      push_valid = 1; push_data = 8'h64; pop = 1;
      @(negedge clk);
      push_valid = 0; pop = 0;
      check("R10 level", fill_level, 3);
      check("R10 oldest gone", pop_data, 8'h62);

      // R7 / R11 exact expiry (trigger 8, 4 bytes held)
      irq_enable = 1;
      push(8'h65);
      idle(WIN - 1);
      check("R7 before", ready, 0);
      idle(1);
      check("R7 at expiry", ready, 1);
      check("R11 irq on", irq, 1);
      irq_enable = 0;
      #0 check("R11 irq gated", irq, 0);

      // R7 restart by later push
      cfg(2'd3, 1'b1);
      push(8'h70);
      idle(20);
      push(8'h71);
      idle(WIN - 1);
      check("R7 restarted", ready, 0);
      idle(1);
      check("R7 restart expiry", ready, 1);

      // R9 flush cancels timer, clears flag
      cfg(2'd3, 1'b1);
      check("R9 flushed", fill_level, 0);
      check("R9 ready", ready, 0);
      push(8'h72);
      idle(10);
      cfg(2'd3, 1'b1);
      idle(WIN + 5);
      check("R9 timer cancelled", ready, 0);

      // R7 empty queue at expiry leaves flag low
      push(8'h73); popone();
      idle(WIN + 5);
      check("R7 empty expiry", ready, 0);

      // R8 reaching trigger cancels timer
      cfg(2'd1, 1'b1);
      push(8'h80); push(8'h81); push(8'h82); push(8'h83);
      popone();
      check("R8 cleared", ready, 0);
      idle(WIN + 5);
      check("R8 no expiry", ready, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule